// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block keeps a small set of outgoing message mailboxes for a CAN-style controller. Each mailbox stores a mode, a 4-bit urgency value, an identifier word, a 64-bit payload, a length code and a remote-request flag. Software fills a mailbox through a single-cycle register write port and then arms it with a control write. Whenever no frame is being offered or carried, the block selects one armed mailbox and offers its frame to a downstream bit-level transmitter over a valid/ready handshake.

Once the transmitter has accepted the frame, it reports one result, either completion or abort. The block then frees the mailbox, records the outcome in its status word and raises that mailbox's pending flag. Pending flags sit at fixed positions of a wider interrupt vector, where the position is the global mailbox number (`MB_BASE` plus the local index). A mask register gates these flags onto a single interrupt line.

Register addresses put the register select in the low 3 bits and the local mailbox index above them. The select codes are: 0 for mode/urgency, 1 for identifier, 2 for payload low word, 3 for payload high word, 4 for control on write and status on read, 5 for interrupt mask and 6 for pending flags (read only). Selects 5 and 6 ignore the mailbox field.

Top module: `tx_mailbox_arbiter`

## Requirements
- R1: After reset every mailbox reads mode 0 (disabled), urgency 0, ready status set (status word 0x0080_0000), abort clear. The pending and mask words read 0, `irq` is low and `tx_valid` is low.
- R2: The mode/urgency register holds the mode in bits 26:24 and the urgency in bits 19:16, and reads back as written. The modes are 0 disabled, 1 receive, 2 receive-with-overwrite, 3 transmit, 4 consumer and 5 producer. A write to this register is ignored while the mailbox is armed.
- R3: In the identifier register, bit 29 set marks an extended frame whose 29-bit ID sits in bits 28:0. Bit 29 clear marks a standard frame whose 11-bit ID sits in bits 28:18. The offered frame shows the ID right-aligned on `tx_ident` and bit 29 on `tx_ext`.
- R4: An identifier write is ignored while the mailbox is in mode 3 (transmit). It is accepted in mode 0 (disabled).
- R5: A control write with bit 23 set arms the mailbox only if the mailbox is in mode 3 and ready. That write stores the length code from bits 19:16 and the remote flag from bit 20, and clears ready (status bit 23), abort (status bit 22) and pending. A control write without bit 23, or to a mailbox in any other mode, leaves the mailbox unarmed.
- R6: Among armed mailboxes, the one with the numerically smallest urgency value is offered first (0 is the most urgent, 15 the least).
- R7: When armed mailboxes tie on urgency, the lowest mailbox index is offered first.
- R8: The choice is made only when no frame is offered or in flight. An offered frame (`tx_mb`, ID, payload) stays unchanged until `tx_ready` is seen, and a more urgent mailbox armed meanwhile waits for the next selection.
- R9: `tx_done` while a frame is in flight sets that mailbox ready, clears abort and sets its pending flag.
- R10: `tx_abort` (without `tx_done`) while a frame is in flight sets that mailbox ready, sets abort (status bit 22) and sets its pending flag.
- R11: Pending flags and mask bits of mailbox i sit at bit `MB_BASE+i` of selects 6 and 5. `irq` is high exactly when some pending flag has its mask bit set.
- R12: The offered payload is `{high word, low word}` on `tx_data`, with length code and remote flag on `tx_dlc` and `tx_rtr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | MB_W+3 | {mailbox index, register select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tx_valid | output | 1 | Frame offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the offered frame |
| tx_mb | output | MB_W | Local index of the offered mailbox |
| tx_ident | output | 29 | Right-aligned frame ID |
| tx_ext | output | 1 | Extended-frame flag |
| tx_rtr | output | 1 | Remote-request flag |
| tx_dlc | output | 4 | Length code |
| tx_data | output | 64 | Payload {high, low} |
| tx_done | input | 1 | In-flight frame completed |
| tx_abort | input | 1 | In-flight frame aborted |
| irq | output | 1 | Masked pending interrupt |

## Verification
The bench builds the block with its defaults: four mailboxes at global interrupt positions 12 to 15 and 4-bit urgency. With four mailboxes, three can be armed behind a frame in flight, so one release of the arbiter meets an urgency winner, an urgency tie and a losing low index at the same time. Position 12 as a base shows that the pending and mask words are placed by global number rather than local index.

// File: rtl/txarb_pkg.sv
package txarb_pkg;

  typedef enum logic [2:0] {
    MB_OFF   = 3'd0,
    MB_RX    = 3'd1,
    MB_RXOVR = 3'd2,
    MB_TX    = 3'd3,
    MB_CONS  = 3'd4,
    MB_PROD  = 3'd5
  } mb_mode_e;

  typedef enum logic [2:0] {
    SEL_MODE  = 3'd0,
    SEL_IDENT = 3'd1,
    SEL_DLO   = 3'd2,
    SEL_DHI   = 3'd3,
    SEL_CTRL  = 3'd4,
    SEL_MASK  = 3'd5,
    SEL_PEND  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OFFER  = 2'd1,
    ST_FLIGHT = 2'd2
  } arb_state_e;

  localparam int CTRL_REQ_BIT = 23;
  localparam int CTRL_RTR_BIT = 20;
  localparam int STAT_RDY_BIT = 23;
  localparam int STAT_ABT_BIT = 22;
  localparam int IDENT_EXT_BIT = 29;

  // right-aligned frame ID from an identifier register value
  function automatic logic [28:0] ident_to_id(input logic [29:0] r);
    if (r[IDENT_EXT_BIT]) return r[28:0];
    return {18'd0, r[28:18]};
  endfunction

  function automatic logic [31:0] mode_word(input mb_mode_e m, input logic [3:0] p);
    logic [31:0] w;
    w = '0;
    w[26:24] = m;
    w[19:16] = p;
    return w;
  endfunction

  function automatic logic [31:0] status_word(input logic rdy, input logic abt,
                                              input logic rtr, input logic [3:0] dlc);
    logic [31:0] w;
    w = '0;
    w[STAT_RDY_BIT] = rdy;
    w[STAT_ABT_BIT] = abt;
    w[CTRL_RTR_BIT] = rtr;
    w[19:16] = dlc;
    return w;
  endfunction

endpackage

// File: rtl/txarb_slot.sv
module txarb_slot
  import txarb_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_ident,
  input  logic              wr_dlo,
  input  logic              wr_dhi,
  input  logic              wr_ctrl,
  input  mb_mode_e          mode_in,
  input  logic [PRIO_W-1:0] prio_in,
  input  logic [29:0]       ident_in,
  input  logic [31:0]       word_in,
  input  logic              req_in,
  input  logic              rtr_in,
  input  logic [3:0]        dlc_in,
  input  logic              res_done,
  input  logic              res_abort,
  output mb_mode_e          mode_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [29:0]       ident_o,
  output logic [31:0]       dlo_o,
  output logic [31:0]       dhi_o,
  output logic [3:0]        dlc_o,
  output logic              rtr_o,
  output logic              ready_o,
  output logic              abort_o,
  output logic              pend_o,
  output logic              arm_req_o
);

  mb_mode_e          mode_q;
  logic [PRIO_W-1:0] prio_q;
  logic [29:0]       ident_q;
  logic [31:0]       dlo_q, dhi_q;
  logic [3:0]        dlc_q;
  logic              rtr_q, ready_q, abort_q, pend_q;

  // named events for the checks below
  logic is_tx, armed, cfg_evt, ident_evt, arm_evt;
  assign is_tx     = (mode_q == MB_TX);
  assign armed     = !ready_q;
  assign cfg_evt   = wr_mode && ready_q;
  assign ident_evt = wr_ident && !is_tx;
  assign arm_evt   = wr_ctrl && req_in && is_tx && ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MB_OFF;
      prio_q  <= '0;
      ident_q <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      dlc_q   <= '0;
      rtr_q   <= 1'b0;
      ready_q <= 1'b1;
      abort_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (cfg_evt) begin
        mode_q <= mode_in;
        prio_q <= prio_in;
      end
      if (ident_evt) ident_q <= ident_in;
      if (wr_dlo && !armed) dlo_q <= word_in;
      if (wr_dhi && !armed) dhi_q <= word_in;
      if (arm_evt) begin
        dlc_q   <= dlc_in;
        rtr_q   <= rtr_in;
        ready_q <= 1'b0;
        abort_q <= 1'b0;
        pend_q  <= 1'b0;
      end
      if (res_done) begin
        ready_q <= 1'b1;
        abort_q <= 1'b0;
        pend_q  <= 1'b1;
      end else if (res_abort) begin
        ready_q <= 1'b1;
        abort_q <= 1'b1;
        pend_q  <= 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign prio_o    = prio_q;
  assign ident_o   = ident_q;
  assign dlo_o     = dlo_q;
  assign dhi_o     = dhi_q;
  assign dlc_o     = dlc_q;
  assign rtr_o     = rtr_q;
  assign ready_o   = ready_q;
  assign abort_o   = abort_q;
  assign pend_o    = pend_q;
  assign arm_req_o = armed && is_tx;

  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(prio_q) && $stable(mode_q)));
  assert_ident_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ident && is_tx) |=> $stable(ident_q));
  assert_arm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> (!ready_q && !pend_q && !abort_q));
  assert_done_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> (ready_q && !abort_q && pend_q));
  assert_abort_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_abort |=> (ready_q && abort_q && pend_q));

endmodule

// File: rtl/txarb_pick.sv
module txarb_pick #(
  parameter int N      = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                req,
  input  logic [N-1:0][PRIO_W-1:0]    prio,
  output logic                        gnt_any,
  output logic [IDX_W-1:0]            gnt_idx
);

  logic [PRIO_W-1:0] best;

  // strict comparison keeps the lower index on equal urgency
  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!gnt_any || prio[i] < best)) begin
        gnt_any = 1'b1;
        gnt_idx = IDX_W'(i);
        best    = prio[i];
      end
    end
  end

  assert_grant_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |-> req[gnt_idx]);

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_urgency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req[g] && gnt_any) |-> (prio[gnt_idx] <= prio[g]));
    assert_tie_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req[g] && gnt_any && prio[g] == prio[gnt_idx]) |-> (gnt_idx <= IDX_W'(g)));
  end

endmodule

// File: rtl/txarb_seq.sv
module txarb_seq
  import txarb_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_any,
  input  logic [IDX_W-1:0] gnt_idx,
  input  logic             tx_ready,
  input  logic             tx_done,
  input  logic             tx_abort,
  output logic             tx_valid,
  output logic [IDX_W-1:0] cur_idx,
  output logic [N-1:0]     res_done_vec,
  output logic [N-1:0]     res_abort_vec
);

  arb_state_e state_q;
  logic       pick_evt, hand_evt, end_evt;

  assign pick_evt = (state_q == ST_IDLE) && gnt_any;
  assign hand_evt = (state_q == ST_OFFER) && tx_ready;
  assign end_evt  = (state_q == ST_FLIGHT) && (tx_done || tx_abort);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_idx <= '0;
    end else begin
      case (state_q)
        ST_IDLE:   if (pick_evt) begin
                     cur_idx <= gnt_idx;
                     state_q <= ST_OFFER;
                   end
        ST_OFFER:  if (hand_evt) state_q <= ST_FLIGHT;
        ST_FLIGHT: if (end_evt) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid = (state_q == ST_OFFER);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      res_done_vec[i]  = end_evt && tx_done && (cur_idx == IDX_W'(i));
      res_abort_vec[i] = end_evt && !tx_done && (cur_idx == IDX_W'(i));
    end
  end

  assert_offer_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(cur_idx)));
  assert_offer_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);
  assert_single_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_done_vec | res_abort_vec));

endmodule

// File: rtl/tx_mailbox_arbiter.sv
module tx_mailbox_arbiter
  import txarb_pkg::*;
#(
  parameter int NUM_MB  = 4,
  parameter int MB_BASE = 12,
  parameter int PRIO_W  = 4,
  localparam int MB_W   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [MB_W+2:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [MB_W-1:0] tx_mb,
  output logic [28:0]     tx_ident,
  output logic            tx_ext,
  output logic            tx_rtr,
  output logic [3:0]      tx_dlc,
  output logic [63:0]     tx_data,
  input  logic            tx_done,
  input  logic            tx_abort,
  output logic            irq
);

  logic [MB_W-1:0] mb_sel;
  reg_sel_e        rsel;
  assign mb_sel = reg_addr[MB_W+2:3];
  assign rsel   = reg_sel_e'(reg_addr[2:0]);

  mb_mode_e [NUM_MB-1:0]          mode_a;
  logic [NUM_MB-1:0][PRIO_W-1:0]  prio_a;
  logic [NUM_MB-1:0][29:0]        ident_a;
  logic [NUM_MB-1:0][31:0]        dlo_a, dhi_a;
  logic [NUM_MB-1:0][3:0]         dlc_a;
  logic [NUM_MB-1:0]              rtr_a, ready_a, abort_a, pend_v, req_v;
  logic [NUM_MB-1:0]              res_done_v, res_abort_v;
  logic [NUM_MB-1:0]              mask_q;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    logic hit;
    assign hit = reg_wr && (mb_sel == MB_W'(g));
    txarb_slot #(.PRIO_W(PRIO_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode   (hit && rsel == SEL_MODE),
      .wr_ident  (hit && rsel == SEL_IDENT),
      .wr_dlo    (hit && rsel == SEL_DLO),
      .wr_dhi    (hit && rsel == SEL_DHI),
      .wr_ctrl   (hit && rsel == SEL_CTRL),
      .mode_in   (mb_mode_e'(reg_wdata[26:24])),
      .prio_in   (reg_wdata[16 +: PRIO_W]),
      .ident_in  (reg_wdata[29:0]),
      .word_in   (reg_wdata),
      .req_in    (reg_wdata[CTRL_REQ_BIT]),
      .rtr_in    (reg_wdata[CTRL_RTR_BIT]),
      .dlc_in    (reg_wdata[19:16]),
      .res_done  (res_done_v[g]),
      .res_abort (res_abort_v[g]),
      .mode_o    (mode_a[g]),
      .prio_o    (prio_a[g]),
      .ident_o   (ident_a[g]),
      .dlo_o     (dlo_a[g]),
      .dhi_o     (dhi_a[g]),
      .dlc_o     (dlc_a[g]),
      .rtr_o     (rtr_a[g]),
      .ready_o   (ready_a[g]),
      .abort_o   (abort_a[g]),
      .pend_o    (pend_v[g]),
      .arm_req_o (req_v[g])
    );
  end

  logic            gnt_any;
  logic [MB_W-1:0] gnt_idx, cur_idx;

  txarb_pick #(.N(NUM_MB), .PRIO_W(PRIO_W)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_v),
    .prio    (prio_a),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  txarb_seq #(.N(NUM_MB)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .gnt_any       (gnt_any),
    .gnt_idx       (gnt_idx),
    .tx_ready      (tx_ready),
    .tx_done       (tx_done),
    .tx_abort      (tx_abort),
    .tx_valid      (tx_valid),
    .cur_idx       (cur_idx),
    .res_done_vec  (res_done_v),
    .res_abort_vec (res_abort_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (reg_wr && rsel == SEL_MASK) mask_q <= reg_wdata[MB_BASE +: NUM_MB];
  end

  always_comb begin
    case (rsel)
      SEL_MODE:  reg_rdata = mode_word(mode_a[mb_sel], 4'(prio_a[mb_sel]));
      SEL_IDENT: reg_rdata = {2'b00, ident_a[mb_sel]};
      SEL_DLO:   reg_rdata = dlo_a[mb_sel];
      SEL_DHI:   reg_rdata = dhi_a[mb_sel];
      SEL_CTRL:  reg_rdata = status_word(ready_a[mb_sel], abort_a[mb_sel],
                                         rtr_a[mb_sel], dlc_a[mb_sel]);
      SEL_MASK:  reg_rdata = 32'(mask_q) << MB_BASE;
      SEL_PEND:  reg_rdata = 32'(pend_v) << MB_BASE;
      default:   reg_rdata = '0;
    endcase
  end

  assign tx_mb    = cur_idx;
  assign tx_ident = ident_to_id(ident_a[cur_idx]);
  assign tx_ext   = ident_a[cur_idx][IDENT_EXT_BIT];
  assign tx_rtr   = rtr_a[cur_idx];
  assign tx_dlc   = dlc_a[cur_idx];
  assign tx_data  = {dhi_a[cur_idx], dlo_a[cur_idx]};
  assign irq      = |(pend_v & mask_q);

  assert_frame_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> ($stable(tx_ident) && $stable(tx_data) && $stable(tx_dlc)));
  assert_offer_is_armed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !ready_a[cur_idx]);
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|pend_v));

endmodule

// File: tb/tb_tx_mailbox_arbiter.sv
module tb_tx_mailbox_arbiter;

  localparam int MB_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [MB_W+2:0] reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            tx_valid, tx_ready = 1'b0;
  logic [MB_W-1:0] tx_mb;
  logic [28:0]     tx_ident;
  logic            tx_ext, tx_rtr;
  logic [3:0]      tx_dlc;
  logic [63:0]     tx_data;
  logic            tx_done = 1'b0, tx_abort = 1'b0;
  logic            irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tx_mailbox_arbiter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_mb(tx_mb), .tx_ident(tx_ident), .tx_ext(tx_ext),
    .tx_rtr(tx_rtr), .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_done(tx_done),
    .tx_abort(tx_abort), .irq(irq)
  );

  function automatic logic [4:0] ad(input int mb, input int sel);
    return {2'(mb), 3'(sel)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_offer(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      if (tx_valid) begin ok = 1'b1; break; end
    end
  endtask

  task automatic accept();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic finish_frame(input bit good);
    @(negedge clk);
    if (good) tx_done = 1'b1; else tx_abort = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; tx_abort = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int m = 0; m < 4; m++) begin
      rd(ad(m, 4), v); check("R1 status", v, 32'h0080_0000);
      rd(ad(m, 0), v); check("R1 mode", v, 32'h0);
    end
    rd(ad(0, 6), v); check("R1 pending", v, 32'h0);
    rd(ad(0, 5), v); check("R1 mask", v, 32'h0);
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
  endtask

  task automatic t_frames();
    logic [31:0] v;
    bit ok;
    wr(ad(0, 1), 32'h21AB_CDEF);
    rd(ad(0, 1), v); check("R4 ident accepted when disabled", v, 32'h21AB_CDEF);
    wr(ad(0, 0), 32'h0305_0000);
    rd(ad(0, 0), v); check("R2 mode/urgency readback", v, 32'h0305_0000);
    wr(ad(0, 1), 32'h0000_0000);
    rd(ad(0, 1), v); check("R4 ident ignored in transmit mode", v, 32'h21AB_CDEF);
    wr(ad(0, 2), 32'h1122_3344);
    wr(ad(0, 3), 32'h5566_7788);
    wr(ad(0, 4), 32'h0088_0000);
    wait_offer(ok);
    check("R5 arm offers frame", ok, 1);
    check("R12 tx_mb", tx_mb, 0);
    check("R3 extended id", tx_ident, 29'h1AB_CDEF);
    check("R3 extended flag", tx_ext, 1);
    check("R12 payload", tx_data, 64'h5566_7788_1122_3344);
    check("R12 dlc", tx_dlc, 8);
    rd(ad(0, 4), v); check("R5 armed status", v, 32'h0008_0000);
    wr(ad(0, 0), 32'h0300_0000);
    rd(ad(0, 0), v); check("R2 mode write ignored while armed", v, 32'h0305_0000);
    // mb1: more urgent, armed while mb0 is on offer
    wr(ad(1, 1), 32'h048C_0000);
    wr(ad(1, 0), 32'h0300_0000);
    wr(ad(1, 2), 32'hA5A5_0001);
    wr(ad(1, 4), 32'h0092_0000);
    repeat (3) @(negedge clk);
    #1 check("R8 offer not pre-empted", tx_mb, 0);
    check("R8 still valid", tx_valid, 1);
    accept();
    finish_frame(1'b1);
    rd(ad(0, 4), v); check("R9 done status", v, 32'h0088_0000);
    rd(ad(0, 6), v); check("R11 pending at bit 12", v, 32'h0000_1000);
    check("R11 irq masked off", irq, 0);
    wr(ad(0, 5), 32'h0000_1000);
    rd(ad(0, 5), v); check("R11 mask readback", v, 32'h0000_1000);
    check("R11 irq unmasked", irq, 1);
    wait_offer(ok);
    check("R8 next offer", ok, 1);
    check("R8 next mailbox", tx_mb, 1);
    check("R3 standard id", tx_ident, 29'h123);
    check("R3 standard flag", tx_ext, 0);
    check("R12 rtr", tx_rtr, 1);
    check("R12 dlc mb1", tx_dlc, 2);
    accept();
    finish_frame(1'b0);
    rd(ad(1, 4), v); check("R10 abort status", v, 32'h00D2_0000);
    rd(ad(0, 6), v); check("R10 pending after abort", v, 32'h0000_3000);
  endtask

  task automatic t_order();
    logic [31:0] v;
    bit ok;
    wr(ad(0, 0), 32'h0309_0000);
    wr(ad(1, 0), 32'h0304_0000);
    wr(ad(2, 0), 32'h0304_0000);
    wr(ad(3, 0), 32'h0302_0000);
    wr(ad(0, 4), 32'h0081_0000);
    rd(ad(0, 6), v); check("R5 arm clears pending", v, 32'h0000_2000);
    wait_offer(ok);
    check("R6 lone mailbox", tx_mb, 0);
    accept();
    wr(ad(1, 4), 32'h0082_0000);
    wr(ad(2, 4), 32'h0083_0000);
    wr(ad(3, 4), 32'h0084_0000);
    finish_frame(1'b1);
    wait_offer(ok);
    check("R6 most urgent first", tx_mb, 3);
    accept(); finish_frame(1'b1);
    wait_offer(ok);
    check("R7 tie lower index", tx_mb, 1);
    accept(); finish_frame(1'b1);
    wait_offer(ok);
    check("R7 tie higher index last", tx_mb, 2);
    accept(); finish_frame(1'b1);
    rd(ad(0, 6), v); check("R11 all pending", v, 32'h0000_F000);
  endtask

  task automatic t_ignored_arm();
    logic [31:0] v;
    wr(ad(2, 0), 32'h0100_0000);
    wr(ad(2, 4), 32'h0080_0000);
    wr(ad(3, 4), 32'h000F_0000);
    repeat (5) @(negedge clk);
    #1 check("R5 no offer", tx_valid, 0);
    rd(ad(2, 4), v); check("R5 receive mode not armed", v, 32'h0083_0000);
    rd(ad(3, 4), v); check("R5 no request bit not armed", v, 32'h0084_0000);
  endtask

  initial begin
    #(8 * 50000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frames();
    t_order();
    t_ignored_arm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule